// File: doc/BRIEF.md
# Register Access Key Sequencer

This block guards a protected register region. It watches every 32-bit write to one key register and decides whether that region is open. Other logic uses the `unlocked` output to gate its address decode. It uses the one-cycle `lock_pulse` output to clear its own interrupt and status state when the region is closed again.

The region starts closed after the power-on reset and after a console reset. To open it, software writes a two-word magic pair to the key register, as two back-to-back key writes. A single all-ones word closes it again. An all-zero word abandons a pair that has been started. The key register is monitored at all times, whether the region is open or closed. The key register cannot be read back, so the block has no read path at all.

An elaboration option adds one register stage on the write inputs. That stage gives the write path a clean timing start, at the cost of one cycle of latency.

Top module: `key_access_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `unlocked` and `lock_pulse` are 0.
- R2: A key write of 0x5F554E4C followed by a key write of 0x4F434B5F on the next key write sets `unlocked` to 1. The change is visible in the cycle after the clock edge that captured the second write.
- R3: Clock cycles with `key_wr` low between the two words of the pair do not break the pair. Only key writes count as consecutive.
- R4: If the first word is followed by any key write other than the second word, the first word, 0x00000000 or 0xFFFFFFFF, the pair is abandoned. A later lone second word does not unlock.
- R5: A key write of 0x00000000 returns the sequence to idle, so a second word after it does not unlock. It leaves `unlocked` unchanged.
- R6: A repeated first word restarts the pair from that word. The sequence first, first, second unlocks.
- R7: A key write of 0xFFFFFFFF while unlocked clears `unlocked` and raises `lock_pulse` for exactly one cycle, both in the cycle after the capturing edge.
- R8: A key write of 0xFFFFFFFF while locked leaves the block locked and produces no `lock_pulse`.
- R9: A high `console_rst` at a clock edge locks the region and returns the sequence to idle, without a `lock_pulse`. It has priority over a simultaneous key write.
- R10: A second word that does not follow a first word does not unlock. Completing the pair while already unlocked keeps `unlocked` at 1 and gives no `lock_pulse`.
- R11: Values on `key_wdata` are ignored while `key_wr` is low. `unlocked` then holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| console_rst | input | 1 | Synchronous active-high console reset |
| key_wr | input | 1 | Write strobe for the key register, one cycle per write |
| key_wdata | input | 32 | Data of the key write |
| unlocked | output | 1 | 1 while the protected region is open |
| lock_pulse | output | 1 | One-cycle event when the region is closed by a key write |

## Verification
The assertions assume two things about the inputs. First, `key_wr` is a single-cycle strobe per write, sampled synchronously. Second, `console_rst` is synchronous to `clk`, so the outputs may change only after a captured write or a console reset.

The stimulus meets these assumptions. It drives all inputs on the falling edge, holds each write for exactly one cycle, and asserts the console reset for single cycles only. The bench also mixes idle cycles into the traffic, so the hold-steady property is exercised with real gaps between writes.

// File: rtl/key_seq_pkg.sv
package key_seq_pkg;

   localparam int KEY_W_DEFAULT = 32;

   typedef enum logic [0:0] {
      SEQ_IDLE  = 1'b0,
      SEQ_ARMED = 1'b1
   } seq_state_t;

   typedef struct packed {
      logic valid;
      logic first;
      logic second;
      logic lock;
      logic clear;
      logic other;
   } key_hit_t;

endpackage

// File: rtl/key_seq_match.sv
module key_seq_match
   import key_seq_pkg::*;
#(
   parameter int                DATA_W     = KEY_W_DEFAULT,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h5F554E4C,
   parameter logic [DATA_W-1:0] KEY_SECOND = 32'h4F434B5F,
   parameter logic [DATA_W-1:0] KEY_LOCK   = '1,
   parameter logic [DATA_W-1:0] KEY_CLEAR  = '0
) (
   input  logic              wr,
   input  logic [DATA_W-1:0] data,
   output key_hit_t          hit
);

   logic is_first, is_second, is_lock, is_clear;

   always_comb begin
      is_first  = (data == KEY_FIRST);
      is_second = (data == KEY_SECOND);
      is_lock   = (data == KEY_LOCK);
      is_clear  = (data == KEY_CLEAR);
      hit.valid  = wr;
      hit.first  = wr && is_first;
      hit.second = wr && is_second;
      hit.lock   = wr && is_lock;
      hit.clear  = wr && is_clear;
      hit.other  = wr && !(is_first || is_second || is_lock || is_clear);
   end

   always_comb begin
      AST_HIT_EXCLUSIVE: assert ($onehot0({hit.first, hit.second, hit.lock, hit.clear, hit.other})); // R4
   end

endmodule

// File: rtl/key_seq_fsm.sv
module key_seq_fsm
   import key_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     console_rst,
   input  key_hit_t hit,
   output logic     unlocked,
   output logic     lock_pulse
);

   seq_state_t seq_q, seq_d;
   logic       unl_q, unl_d;
   logic       pulse_q, pulse_d;
   logic       chk_q;

   always_comb begin
      seq_d   = seq_q;
      unl_d   = unl_q;
      pulse_d = 1'b0;
      if (console_rst) begin
         seq_d = SEQ_IDLE;
         unl_d = 1'b0;
      end else if (hit.valid) begin
         seq_d = SEQ_IDLE;
         if (hit.first) begin
            seq_d = SEQ_ARMED;
         end else if (hit.second) begin
            if (seq_q == SEQ_ARMED) unl_d = 1'b1;
         end else if (hit.lock) begin
            if (unl_q) pulse_d = 1'b1;
            unl_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q   <= SEQ_IDLE;
         unl_q   <= 1'b0;
         pulse_q <= 1'b0;
         chk_q   <= 1'b0;
      end else begin
         seq_q   <= seq_d;
         unl_q   <= unl_d;
         pulse_q <= pulse_d;
         chk_q   <= 1'b1;
      end
   end

   assign unlocked   = unl_q;
   assign lock_pulse = pulse_q;

   AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      chk_q && $rose(unl_q) |-> $past(hit.second) && $past(seq_q == SEQ_ARMED)); // R2
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q); // R7
   AST_PULSE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> !unl_q); // R7
   AST_LOCKED_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      chk_q && !$past(unl_q) |-> !pulse_q); // R8
   AST_CONSOLE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      console_rst |=> !unl_q && !pulse_q); // R9
   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      chk_q && !$past(hit.valid) && !$past(console_rst) |-> $stable(unl_q)); // R11

endmodule

// File: rtl/key_access_seq.sv
module key_access_seq
   import key_seq_pkg::*;
#(
   parameter int                DATA_W     = KEY_W_DEFAULT,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 32'h5F554E4C,
   parameter logic [DATA_W-1:0] KEY_SECOND = 32'h4F434B5F,
   parameter logic [DATA_W-1:0] KEY_LOCK   = '1,
   parameter logic [DATA_W-1:0] KEY_CLEAR  = '0,
   parameter bit                REG_INPUT  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              console_rst,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] key_wdata,
   output logic              unlocked,
   output logic              lock_pulse
);

   localparam int NUM_KEYS = 4;

   initial begin
      AST_PARAM_WIDTH: assert (DATA_W >= 8) else $error("key width too small"); // R2
      AST_PARAM_DISTINCT: assert (KEY_FIRST != KEY_SECOND && KEY_FIRST != KEY_LOCK &&
                                  KEY_FIRST != KEY_CLEAR && KEY_SECOND != KEY_LOCK &&
                                  KEY_SECOND != KEY_CLEAR && KEY_LOCK != KEY_CLEAR)
         else $error("the %0d key values must differ", NUM_KEYS); // R4
   end

   logic              wr_s;
   logic [DATA_W-1:0] data_s;
   key_hit_t          hit;

   generate
      if (REG_INPUT) begin : g_in_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_s   <= 1'b0;
               data_s <= '0;
            end else begin
               wr_s   <= key_wr && !console_rst;
               data_s <= key_wdata;
            end
         end
      end else begin : g_in_pass
         assign wr_s   = key_wr;
         assign data_s = key_wdata;
      end
   endgenerate

   key_seq_match #(
      .DATA_W     (DATA_W),
      .KEY_FIRST  (KEY_FIRST),
      .KEY_SECOND (KEY_SECOND),
      .KEY_LOCK   (KEY_LOCK),
      .KEY_CLEAR  (KEY_CLEAR)
   ) match_i (
      .wr   (wr_s),
      .data (data_s),
      .hit  (hit)
   );

   key_seq_fsm fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .console_rst (console_rst),
      .hit         (hit),
      .unlocked    (unlocked),
      .lock_pulse  (lock_pulse)
   );

endmodule

// File: tb/key_access_seq_tb_top.sv
module key_access_seq_tb_top;

   localparam logic [31:0] K1   = 32'h5F554E4C;
   localparam logic [31:0] K2   = 32'h4F434B5F;
   localparam logic [31:0] KLK  = 32'hFFFFFFFF;
   localparam logic [31:0] KCLR = 32'h00000000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        console_rst = 1'b0;
   logic        key_wr = 1'b0;
   logic [31:0] key_wdata = '0;
   logic        unlocked, lock_pulse;

   int checks = 0;
   int failures = 0;

   typedef struct {
      logic  unl;
      logic  pul;
      string req;
   } exp_t;

   exp_t exp_q[$];
   bit   m_unl = 1'b0;
   bit   m_arm = 1'b0;
   bit   done  = 1'b0;

   always #5 clk = ~clk;

   key_access_seq dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .console_rst (console_rst),
      .key_wr      (key_wr),
      .key_wdata   (key_wdata),
      .unlocked    (unlocked),
      .lock_pulse  (lock_pulse)
   );

   task automatic check(input logic act_u, input logic act_p, input logic exp_u,
                        input logic exp_p, input string req);
      checks++;
      if (act_u !== exp_u || act_p !== exp_p) begin
         failures++;
         $display("FAIL %s unlocked=%b lock_pulse=%b expected unlocked=%b lock_pulse=%b",
                  req, act_u, act_p, exp_u, exp_p);
      end
   endtask

   task automatic drive(input bit wr, input logic [31:0] d, input bit nmi, input string req);
      exp_t e;
      bit   pul;
      @(negedge clk);
      key_wr      = wr;
      key_wdata   = d;
      console_rst = nmi;
      pul = 1'b0;
      if (nmi) begin
         m_unl = 1'b0;
         m_arm = 1'b0;
      end else if (wr) begin
         if (d == K1) m_arm = 1'b1;
         else begin
            if (d == K2 && m_arm) m_unl = 1'b1;
            if (d == KLK) begin
               pul   = m_unl;
               m_unl = 1'b0;
            end
            m_arm = 1'b0;
         end
      end
      e.unl = m_unl;
      e.pul = pul;
      e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic wkey(input logic [31:0] d, input string req);
      drive(1'b1, d, 1'b0, req);
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) drive(1'b0, 32'hA5A5_0000 + i, 1'b0, req);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(unlocked, lock_pulse, e.unl, e.pul, e.req);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check(unlocked, lock_pulse, 1'b0, 1'b0, "R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      idle(2, "R1 after reset");
      // R2 basic unlock
      wkey(K1, "R2 first word");
      wkey(K2, "R2 second word");
      // R10 pair again while unlocked
      wkey(K1, "R10 first while unlocked");
      wkey(K2, "R10 pair while unlocked");
      // R7 lock
      wkey(KLK, "R7 lock write");
      idle(1, "R7 pulse ends");
      // R8 lock while locked
      wkey(KLK, "R8 lock while locked");
      idle(1, "R8 no pulse");
      // R3 gaps inside pair
      wkey(K1, "R3 first word");
      idle(3, "R3 gap");
      wkey(K2, "R3 second after gap");
      wkey(KLK, "R7 lock again");
      // R11 data ignored without strobe
      drive(1'b0, K1, 1'b0, "R11 no strobe first");
      drive(1'b0, K2, 1'b0, "R11 no strobe second");
      idle(1, "R11 still locked");
      // R4 mismatch aborts
      wkey(K1, "R4 first word");
      wkey(32'h1234_5678, "R4 wrong word");
      wkey(K2, "R4 lone second");
      // R5 clear aborts
      wkey(K1, "R5 first word");
      wkey(KCLR, "R5 clear");
      wkey(K2, "R5 second after clear");
      // R10 lone second
      wkey(K2, "R10 lone second");
      // R6 repeated first
      wkey(K1, "R6 first");
      wkey(K1, "R6 first again");
      wkey(K2, "R6 second");
      // R5 clear keeps unlocked
      wkey(KCLR, "R5 clear while unlocked");
      // R9 console reset locks, no pulse, priority over write
      drive(1'b1, K2, 1'b1, "R9 console reset");
      idle(1, "R9 no pulse");
      wkey(K1, "R9 first before reset");
      drive(1'b0, '0, 1'b1, "R9 reset kills pair");
      wkey(K2, "R9 second after reset");
      wkey(K1, "R9 relock first");
      wkey(K2, "R9 relock second");
      drive(1'b1, KLK, 1'b1, "R9 reset beats lock write");
      idle(3, "final idle");
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL scoreboard not drained: %0d left", exp_q.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule